// File: doc/BRIEF.md
# Octal Double-Buffered DAC Register Bank

This block is the digital front end of an eight-channel, 14-bit voltage-output converter. A host writes a 14-bit code over a parallel port into one of eight staging registers, picking the channel with a 3-bit address. Each write is framed by two active-low strobes, a chip select and a write strobe. A separate active-low load strobe copies every staging word into the matching output register in one step. The output registers feed the converter cores. When the load strobe is held low permanently, the bank becomes transparent, and a write reaches the converter on the same strobe edge.

All strobes are asynchronous to the block clock. They pass through two-flop synchronisers. A write is taken at the end of the combined select-and-write pulse, the moment either strobe goes high again. An active-low clear forces every channel's output word to zero and raises a flag that tells the analog stage to park on its sense ground. The clear acts at once, without waiting for a clock edge, and it leaves both register ranks untouched.

Top module: `octal_dac_regbank`

## Requirements
- R1: The address `chan_sel` is read as an unsigned index 0 to 7, and a write lands only in that channel. Channel n is presented on `chan_words[14*n+13 : 14*n]`.
- R2: A staging register is written only when `cs_n` and `wr_n` have been low together. The capture happens on the rising edge of that combined low level, whichever strobe rises first. Pulsing either strobe alone while the other stays high changes nothing.
- R3: Codes pass through as straight 14-bit binary, with bit 13 the MSB and bit 0 the LSB. The values 0x0001, 0x2000 and 0x3FFF appear unaltered on the output.
- R4: While the synchronised `load_n` is low, each output register takes its staging register's value. While `load_n` is high, the output registers hold, even across writes.
- R5: With `load_n` held low, a write updates the addressed channel's output and leaves every other channel unchanged.
- R6: While `clr_n` is low, every 14-bit field of `chan_words` reads zero and `clr_active` is 1, with no clock edge needed.
- R7: Clear does not modify either register rank. Writes and loads made during clear still take effect. When `clr_n` rises, the outputs show the output-register contents again.
- R8: After reset, both ranks hold zero and `clr_active` follows `clr_n`.
- R9: If a write capture and a one-cycle load fall in the same clock cycle, the output register receives the newly written code.
- R10: With the load already active, the output changes on the third rising clock edge after the write strobes rise, counting the first edge that sees them high as the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_sel | input | 3 | Channel index for the write |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe |
| wr_code | input | 14 | Code to write, bit 13 MSB |
| load_n | input | 1 | Active-low global load, level sensitive |
| clr_n | input | 1 | Active-low asynchronous clear |
| chan_words | output | 112 | Eight 14-bit output words, channel 0 in the low bits |
| clr_active | output | 1 | High while the outputs are forced to ground level |

## Verification
The hardest case to reach is R9, where a write capture and a load that lasts only one cycle meet in the same clock cycle. If that case is handled wrongly, the stale staging value is copied and the fresh code is stranded in the staging rank. To create it, the bench raises the write strobes and drops `load_n` on the same falling clock edge, then releases `load_n` one cycle later. The two synchroniser paths then deliver both events to the bank in the same cycle. A second case that depends on timing is the cycle-exact latency check. It samples the output after each of the three edges that follow the strobe release.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;

  localparam int DEF_CHANNELS = 8;
  localparam int DEF_DATA_W   = 14;
  localparam int DEF_SYNC     = 2;

  // combined strobe: active when both active-low inputs are low
  function automatic logic both_low(input logic a_n, input logic b_n);
    return ~a_n & ~b_n;
  endfunction

  // end of an active-high level seen across two consecutive samples
  function automatic logic level_ended(input logic older, input logic newer);
    return older & ~newer;
  endfunction

endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/dacfe_wrport.sv
module dacfe_wrport
  import dacfe_pkg::*;
#(
  parameter int CHANNELS = DEF_CHANNELS,
  parameter int DATA_W   = DEF_DATA_W,
  parameter int SYNC     = DEF_SYNC,
  localparam int ADDR_W  = $clog2(CHANNELS),
  localparam int BUS_W   = ADDR_W + DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] chan_sel,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic [DATA_W-1:0] wr_code,
  output logic              wr_pulse,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);

  logic act_raw, act_s, act_d;
  logic [BUS_W-1:0] bus_raw, bus_d;

  assign act_raw = both_low(cs_n, wr_n);

  dacfe_sync #(.W(1), .STAGES(SYNC)) act_sync_i (
    .clk(clk), .rst_n(rst_n), .d(act_raw), .q(act_s)
  );

  // one more flop so the previous synchronised level is available
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_d <= 1'b0;
    else        act_d <= act_s;
  end

  // address/data delayed by SYNC+1 so they line up with act_d,
  // i.e. the last sample taken while the strobes were still active
  assign bus_raw = {chan_sel, wr_code};

  dacfe_sync #(.W(BUS_W), .STAGES(SYNC + 1)) bus_pipe_i (
    .clk(clk), .rst_n(rst_n), .d(bus_raw), .q(bus_d)
  );

  assign wr_pulse = level_ended(act_d, act_s);
  assign wr_addr  = bus_d[BUS_W-1 -: ADDR_W];
  assign wr_data  = bus_d[DATA_W-1:0];

  // R2
  wr_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |=> !wr_pulse);

  // R2
  wr_pulse_after_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |-> $past(act_s));

endmodule

// File: rtl/dacfe_bank.sv
module dacfe_bank
  import dacfe_pkg::*;
#(
  parameter int CHANNELS = DEF_CHANNELS,
  parameter int DATA_W   = DEF_DATA_W,
  localparam int ADDR_W  = $clog2(CHANNELS),
  localparam int FLAT_W  = CHANNELS * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_pulse,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              load_act,
  output logic [FLAT_W-1:0] dac_flat
);

  function automatic logic [CHANNELS-1:0] chan_onehot(input logic en,
                                                      input logic [ADDR_W-1:0] a);
    logic [CHANNELS-1:0] v;
    v = '0;
    for (int c = 0; c < CHANNELS; c++) v[c] = en && (a == ADDR_W'(c));
    return v;
  endfunction

  logic [CHANNELS-1:0] wr_sel;
  logic [DATA_W-1:0]   stage_q [CHANNELS];
  logic [DATA_W-1:0]   stage_nx[CHANNELS];
  logic [DATA_W-1:0]   dac_q   [CHANNELS];

  assign wr_sel = chan_onehot(wr_pulse, wr_addr);

  // R1
  wr_sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_sel));

  for (genvar i = 0; i < CHANNELS; i++) begin : g_chan
    // staging value including a write landing this cycle
    assign stage_nx[i] = wr_sel[i] ? wr_data : stage_q[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[i] <= '0;
        dac_q[i]   <= '0;
      end else begin
        stage_q[i] <= stage_nx[i];
        if (load_act) dac_q[i] <= stage_nx[i];
      end
    end

    assign dac_flat[i*DATA_W +: DATA_W] = dac_q[i];

    // R4
    load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load_act && !(wr_pulse && wr_addr == ADDR_W'(i))) |=> dac_q[i] == $past(stage_q[i]));

    // R4
    load_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load_act |=> $stable(dac_q[i]));

    // R9
    same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_pulse && load_act && wr_addr == ADDR_W'(i)) |=> dac_q[i] == $past(wr_data));

    // R1
    other_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_pulse && wr_addr != ADDR_W'(i)) |=> $stable(stage_q[i]));
  end

endmodule

// File: rtl/octal_dac_regbank.sv
module octal_dac_regbank
  import dacfe_pkg::*;
#(
  parameter int CHANNELS = DEF_CHANNELS,
  parameter int DATA_W   = DEF_DATA_W,
  parameter int SYNC     = DEF_SYNC,
  localparam int ADDR_W  = $clog2(CHANNELS),
  localparam int FLAT_W  = CHANNELS * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] chan_sel,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic [DATA_W-1:0] wr_code,
  input  logic              load_n,
  input  logic              clr_n,
  output logic [FLAT_W-1:0] chan_words,
  output logic              clr_active
);

  function automatic logic [DATA_W-1:0] park_word(input logic [DATA_W-1:0] w,
                                                  input logic clr_lvl);
    return clr_lvl ? '0 : w;
  endfunction

  logic              wr_pulse;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic              load_act;
  logic [FLAT_W-1:0] dac_flat;

  dacfe_wrport #(.CHANNELS(CHANNELS), .DATA_W(DATA_W), .SYNC(SYNC)) wrport_i (
    .clk(clk), .rst_n(rst_n), .chan_sel(chan_sel), .cs_n(cs_n), .wr_n(wr_n),
    .wr_code(wr_code), .wr_pulse(wr_pulse), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  dacfe_sync #(.W(1), .STAGES(SYNC)) load_sync_i (
    .clk(clk), .rst_n(rst_n), .d(~load_n), .q(load_act)
  );

  dacfe_bank #(.CHANNELS(CHANNELS), .DATA_W(DATA_W)) bank_i (
    .clk(clk), .rst_n(rst_n), .wr_pulse(wr_pulse), .wr_addr(wr_addr),
    .wr_data(wr_data), .load_act(load_act), .dac_flat(dac_flat)
  );

  // clear acts on the raw pin: no clock needed to park the outputs
  assign clr_active = ~clr_n;

  for (genvar i = 0; i < CHANNELS; i++) begin : g_out
    assign chan_words[i*DATA_W +: DATA_W] =
      park_word(dac_flat[i*DATA_W +: DATA_W], clr_active);
  end

  // R6
  clear_parks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> (chan_words == '0) && clr_active);

  // R7
  clear_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && !load_act && $past(!load_act)) |-> $stable(dac_flat));

endmodule

// File: tb/octal_dac_regbank_tb_top.sv
module octal_dac_regbank_tb_top;

  localparam int CH = 8;
  localparam int DW = 14;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [2:0]    chan_sel;
  logic          cs_n, wr_n, load_n, clr_n;
  logic [DW-1:0] wr_code;
  logic [CH*DW-1:0] chan_words;
  logic          clr_active;

  int checks = 0;
  int errors = 0;

  typedef struct {
    int            ch;
    logic [DW-1:0] val;
    string         tag;
  } exp_t;

  exp_t exp_q[$];

  always #5 clk = ~clk;

  octal_dac_regbank dut_i (
    .clk(clk), .rst_n(rst_n), .chan_sel(chan_sel), .cs_n(cs_n), .wr_n(wr_n),
    .wr_code(wr_code), .load_n(load_n), .clr_n(clr_n),
    .chan_words(chan_words), .clr_active(clr_active)
  );

  task automatic check_word(input int ch, input logic [DW-1:0] expv, input string tag);
    logic [DW-1:0] act;
    act = chan_words[ch*DW +: DW];
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s ch%0d actual 0x%04h expected 0x%04h", tag, ch, act, expv);
    end
  endtask

  task automatic check_flag(input logic expv, input string tag);
    checks++;
    if (clr_active !== expv) begin
      errors++;
      $display("FAIL %s clr_active actual %b expected %b", tag, clr_active, expv);
    end
  endtask

  // monitor: compares queued expectations at the falling edge
  always @(negedge clk) begin
    while (exp_q.size() != 0) begin
      exp_t it;
      it = exp_q.pop_front();
      check_word(it.ch, it.val, it.tag);
    end
  end

  task automatic push_exp(input int ch, input logic [DW-1:0] v, input string tag);
    exp_t it;
    it.ch = ch; it.val = v; it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic sync_point();
    @(posedge clk); #2;
  endtask

  task automatic do_write(input int ch, input logic [DW-1:0] v);
    @(negedge clk);
    chan_sel = 3'(ch); wr_code = v; cs_n = 1'b0; wr_n = 1'b0;
    repeat (3) @(negedge clk);
    wr_n = 1'b1; cs_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic load_pulse();
    @(negedge clk); load_n = 1'b0;
    @(negedge clk); load_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    repeat (2) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  logic [DW-1:0] vals [CH];

  initial begin
    vals[0] = 14'h0001; vals[1] = 14'h1111; vals[2] = 14'h0ABC; vals[3] = 14'h1F0F;
    vals[4] = 14'h2468; vals[5] = 14'h3333; vals[6] = 14'h2000; vals[7] = 14'h3FFF;

    rst_n = 1'b0; chan_sel = '0; wr_code = '0;
    cs_n = 1'b1; wr_n = 1'b1; load_n = 1'b1; clr_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R8: reset state
    sync_point();
    for (int c = 0; c < CH; c++) push_exp(c, '0, "R8 reset");
    check_flag(1'b0, "R8 reset flag");

    // R4: load high holds outputs across a write
    do_write(2, 14'h1234);
    sync_point();
    push_exp(2, '0, "R4 hold while load high");
    load_pulse();
    sync_point();
    push_exp(2, 14'h1234, "R4 load copies");

    // R1 R3: all channels, distinct codes
    for (int c = 0; c < CH; c++) do_write(c, vals[c]);
    sync_point();
    push_exp(0, '0, "R4 hold before load");
    push_exp(2, 14'h1234, "R4 hold before load");
    load_pulse();
    sync_point();
    for (int c = 0; c < CH; c++) push_exp(c, vals[c], "R1 R3 channel decode");

    // R2: one strobe alone does nothing
    @(negedge clk);
    chan_sel = 3'd1; wr_code = 14'h0000; cs_n = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); wr_n = 1'b0;
      repeat (3) @(negedge clk); wr_n = 1'b1;
    end
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); cs_n = 1'b0;
      repeat (3) @(negedge clk); cs_n = 1'b1;
    end
    repeat (4) @(negedge clk);
    load_pulse();
    sync_point();
    push_exp(1, 14'h1111, "R2 single strobe ignored");

    // R2: chip select rising first ends the write
    @(negedge clk);
    chan_sel = 3'd1; wr_code = 14'h0555; cs_n = 1'b0; wr_n = 1'b0;
    repeat (3) @(negedge clk); cs_n = 1'b1;
    repeat (2) @(negedge clk); wr_n = 1'b1;
    repeat (4) @(negedge clk);
    load_pulse();
    sync_point();
    push_exp(1, 14'h0555, "R2 cs rise captures");

    // R9: write capture and one-cycle load in the same cycle
    @(negedge clk);
    chan_sel = 3'd4; wr_code = 14'h0F0F; cs_n = 1'b0; wr_n = 1'b0;
    repeat (3) @(negedge clk);
    wr_n = 1'b1; cs_n = 1'b1; load_n = 1'b0;
    @(negedge clk); load_n = 1'b1;
    repeat (4) @(negedge clk);
    sync_point();
    push_exp(4, 14'h0F0F, "R9 coincident write and load");

    // R5 R10: transparent mode and its latency
    @(negedge clk); load_n = 1'b0;
    repeat (4) @(negedge clk);
    chan_sel = 3'd3; wr_code = 14'h2AAA; cs_n = 1'b0; wr_n = 1'b0;
    repeat (3) @(negedge clk);
    wr_n = 1'b1; cs_n = 1'b1;
    sync_point(); push_exp(3, 14'h1F0F, "R10 edge 1 old");
    sync_point(); push_exp(3, 14'h1F0F, "R10 edge 2 old");
    sync_point(); push_exp(3, 14'h2AAA, "R10 edge 3 new");
    push_exp(0, 14'h0001, "R5 other channel unchanged");
    push_exp(7, 14'h3FFF, "R5 other channel unchanged");
    repeat (3) @(negedge clk);
    load_n = 1'b1;
    repeat (4) @(negedge clk);

    // R6: asynchronous clear, no clock edge in between
    #3; clr_n = 1'b0;
    #1;
    for (int c = 0; c < CH; c++) check_word(c, '0, "R6 clear parks");
    check_flag(1'b1, "R6 clear flag");

    // R7: write and load during clear still land
    do_write(5, 14'h0777);
    load_pulse();
    sync_point();
    push_exp(5, '0, "R6 still parked");
    @(negedge clk);
    #3; clr_n = 1'b1;
    #1;
    check_flag(1'b0, "R7 clear released");
    check_word(5, 14'h0777, "R7 write during clear kept");
    check_word(7, 14'h3FFF, "R7 rank untouched");
    check_word(0, 14'h0001, "R7 rank untouched");
    check_word(4, 14'h0F0F, "R7 rank untouched");

    finish_run();
  end

endmodule